// File: doc/BRIEF.md
# UART Modem Control and Status with Internal Loopback

This block holds the modem control and modem status state of a 16550-class serial port. The control side keeps five writable bits that drive the four outgoing handshake lines and select internal loopback. The status side tracks the four incoming handshake lines in the upper half of an 8-bit status word. The lower half holds sticky change flags that the host reads and clears.

In normal operation the incoming lines pass through a two-flop synchronizer and are then compared against the previously registered status. In loopback the control bits feed the status bits directly, the external lines are ignored, and the outgoing request-to-send and terminal-ready pins are held inactive. Whenever any change flag is set, a level event output asks the interrupt logic for service.

Top module: `uart_modem_ctl`

## Requirements
- R1: After a synchronous active-low reset the status word, the control read value, all four outgoing pins and the event output are zero.
- R2: A control write stores data bits 4:0 (bit 0 terminal-ready, bit 1 request-to-send, bit 2 aux output 1, bit 3 aux output 2, bit 4 loopback), visible on the next cycle. Control read bits 7:5 are always zero.
- R3: Outside loopback, pin_dtr, pin_rts, pin_out1 and pin_out2 equal control bits 0, 1, 2 and 3.
- R4: In loopback, pin_rts and pin_dtr are 0. pin_out1 and pin_out2 still follow their control bits.
- R5: Outside loopback, status bits 4 (clear-to-send), 5 (set-ready), 6 (ring) and 7 (carrier) show the external lines. A line change made before a clock edge appears after the third rising edge.
- R6: In loopback, status bit 4 takes control bit 1, bit 5 takes bit 0, bit 6 takes bit 2 and bit 7 takes bit 3, one cycle after the control register. External line changes have no effect.
- R7: A change of clear-to-send, set-ready or carrier in the registered status sets change flag bit 0, 1 or 3 respectively.
- R8: Ring change flag bit 2 is set only when the ring status falls from 1 to 0. A rising ring status leaves it clear.
- R9: Change flags are sticky. New flags are ORed in, and no status update clears an existing flag.
- R10: msr_rd_data shows the full status word. A cycle with msr_rd_en high clears flags 3:0 at that edge while keeping status bits 7:4. A flag raised at the same edge survives.
- R11: An MSR write ORs data bits 3:0 into the change flags and leaves status bits 7:4 untouched.
- R12: modem_evt is high exactly when any change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_cts | input | 1 | External clear-to-send, 1 = asserted |
| line_dsr | input | 1 | External set-ready, 1 = asserted |
| line_ri | input | 1 | External ring indicator, 1 = asserted |
| line_dcd | input | 1 | External carrier detect, 1 = asserted |
| mcr_wr_en | input | 1 | Control register write strobe |
| mcr_wr_data | input | 8 | Control register write data |
| mcr_rd_data | output | 8 | Control register read value |
| msr_wr_en | input | 1 | Status register write strobe (change flags only) |
| msr_wr_data | input | 8 | Status register write data |
| msr_rd_en | input | 1 | Status register read strobe, clears change flags |
| msr_rd_data | output | 8 | Status word: lines in 7:4, change flags in 3:0 |
| pin_dtr | output | 1 | Outgoing terminal-ready |
| pin_rts | output | 1 | Outgoing request-to-send |
| pin_out1 | output | 1 | Outgoing auxiliary output 1 |
| pin_out2 | output | 1 | Outgoing auxiliary output 2 |
| modem_evt | output | 1 | Modem-status event, high while any change flag is set |

## Verification
The hardest case to reach is a status read landing on the same edge that a new change flag is raised. If the read's clear wins, the event is lost. The external path has a three-edge latency, so the stimulus uses loopback: it writes the control register to flip a carrier-mapped bit and asserts the read strobe on the very next edge, which is the edge where the flag forms. The ring trailing-edge rule is also driven both ways, a rise and then a fall, with a read between them so the flag state is known.

// File: rtl/uart_modem_pkg.sv
// Package: shared widths, bit positions and the loopback cross-wiring
// used by the modem control/status block.
package uart_modem_pkg;
    localparam int REG_W  = 8;   // host-visible register width
    localparam int CTL_W  = 5;   // writable control bits
    localparam int LINE_W = 4;   // modem status lines

    // control bit positions
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_AUX1 = 2;
    localparam int CTL_AUX2 = 3;
    localparam int CTL_LOOP = 4;

    // status line positions inside the 4-bit line vector
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // Builds the line vector that loopback presents to the status side.
    function automatic logic [LINE_W-1:0] loop_lines(input logic [CTL_W-1:0] ctl);
        logic [LINE_W-1:0] l;
        l[LN_CTS] = ctl[CTL_RTS];
        l[LN_DSR] = ctl[CTL_DTR];
        l[LN_RI]  = ctl[CTL_AUX1];
        l[LN_DCD] = ctl[CTL_AUX2];
        return l;
    endfunction
endpackage

// File: rtl/modem_line_sync.sv
// Module: modem_line_sync
// Multi-stage flop synchronizer for a bus of independent level signals.
// Assumes each bit is an unrelated slow line; no cross-bit coherence.
module modem_line_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Stage 0 captures the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    // Later stages shift the captured value along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/modem_ctrl_reg.sv
// Module: modem_ctrl_reg
// Holds the writable control bits and drives the outgoing handshake pins.
// Assumes writes take effect on the clock edge of the strobe.
module modem_ctrl_reg
    import uart_modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctl_q,
    output logic             dtr_o,
    output logic             rts_o,
    output logic             aux1_o,
    output logic             aux2_o
);
    logic in_loop;

    // Register the writable control field.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data[CTL_W-1:0];
    end

    // Pin drive: loopback holds the two handshake requests inactive.
    always_comb begin
        in_loop = ctl_q[CTL_LOOP];
        dtr_o   = ctl_q[CTL_DTR] & ~in_loop;
        rts_o   = ctl_q[CTL_RTS] & ~in_loop;
        aux1_o  = ctl_q[CTL_AUX1];
        aux2_o  = ctl_q[CTL_AUX2];
    end

    assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_q == $past(wr_data[CTL_W-1:0]));

    assert_loop_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CTL_LOOP] |-> (!rts_o && !dtr_o));
endmodule

// File: rtl/modem_status_reg.sv
// Module: modem_status_reg
// Registers the line status and keeps sticky change flags. The ring flag
// is trailing-edge only. A read clears the flags, a host write ORs flags in.
// Assumes the line vector is already synchronous to clk.
module modem_status_reg
    import uart_modem_pkg::*;
#(
    parameter int RI_BIT = LN_RI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lines_i,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_flags,
    output logic [LINE_W-1:0] stat_q,
    output logic [LINE_W-1:0] flag_q
);
    logic [LINE_W-1:0] edge_det;
    logic [LINE_W-1:0] flag_d;

    // Per-line change detect; the ring line reacts to its falling edge only.
    for (genvar i = 0; i < LINE_W; i++) begin : g_edge
        if (i == RI_BIT) begin : g_trail
            assign edge_det[i] = stat_q[i] & ~lines_i[i];
        end else begin : g_any
            assign edge_det[i] = stat_q[i] ^ lines_i[i];
        end
    end

    // Next flag value: cleared by a read, new edges and host flags ORed in.
    always_comb begin
        flag_d = (rd_en ? '0 : flag_q) | edge_det | (wr_en ? wr_flags : '0);
    end

    // Status and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            flag_q <= '0;
        end else begin
            stat_q <= lines_i;
            flag_q <= flag_d;
        end
    end

    assert_sticky_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && edge_det == '0) |=> flag_q == '0);

    assert_ring_rise_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q[RI_BIT] && lines_i[RI_BIT] && !flag_q[RI_BIT] && !wr_en)
        |=> !flag_q[RI_BIT]);
endmodule

// File: rtl/uart_modem_ctl.sv
// Module: uart_modem_ctl (top)
// Modem control and status of a 16550-class port with internal loopback.
// Assumes external lines are asynchronous and active-high; the interrupt
// encoder and character loopback live elsewhere.
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_cts,
    input  logic       line_dsr,
    input  logic       line_ri,
    input  logic       line_dcd,
    input  logic       mcr_wr_en,
    input  logic [7:0] mcr_wr_data,
    output logic [7:0] mcr_rd_data,
    input  logic       msr_wr_en,
    input  logic [7:0] msr_wr_data,
    input  logic       msr_rd_en,
    output logic [7:0] msr_rd_data,
    output logic       pin_dtr,
    output logic       pin_rts,
    output logic       pin_out1,
    output logic       pin_out2,
    output logic       modem_evt
);
    logic [LINE_W-1:0] raw_lines;
    logic [LINE_W-1:0] sync_lines;
    logic [LINE_W-1:0] sel_lines;
    logic [CTL_W-1:0]  ctl_q;
    logic [LINE_W-1:0] stat_q;
    logic [LINE_W-1:0] flag_q;

    // Gather the external lines in status order.
    always_comb begin
        raw_lines         = '0;
        raw_lines[LN_CTS] = line_cts;
        raw_lines[LN_DSR] = line_dsr;
        raw_lines[LN_RI]  = line_ri;
        raw_lines[LN_DCD] = line_dcd;
    end

    modem_line_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    modem_ctrl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mcr_wr_en),
        .wr_data (mcr_wr_data),
        .ctl_q   (ctl_q),
        .dtr_o   (pin_dtr),
        .rts_o   (pin_rts),
        .aux1_o  (pin_out1),
        .aux2_o  (pin_out2)
    );

    // Source select: loopback replaces the external lines with control bits.
    always_comb begin
        sel_lines = ctl_q[CTL_LOOP] ? loop_lines(ctl_q) : sync_lines;
    end

    modem_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_i  (sel_lines),
        .rd_en    (msr_rd_en),
        .wr_en    (msr_wr_en),
        .wr_flags (msr_wr_data[LINE_W-1:0]),
        .stat_q   (stat_q),
        .flag_q   (flag_q)
    );

    // Host-visible read values and the event level.
    always_comb begin
        mcr_rd_data = {{(REG_W-CTL_W){1'b0}}, ctl_q};
        msr_rd_data = {stat_q, flag_q};
        modem_evt   = |flag_q;
    end

    assert_evt_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        modem_evt == (msr_rd_data[3:0] != 4'h0));
endmodule

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_cts = 0, line_dsr = 0, line_ri = 0, line_dcd = 0;
    logic       mcr_wr_en = 0, msr_wr_en = 0, msr_rd_en = 0;
    logic [7:0] mcr_wr_data = 0, msr_wr_data = 0;
    logic [7:0] mcr_rd_data, msr_rd_data;
    logic       pin_dtr, pin_rts, pin_out1, pin_out2, modem_evt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_modem_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
        .mcr_wr_en(mcr_wr_en), .mcr_wr_data(mcr_wr_data), .mcr_rd_data(mcr_rd_data),
        .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
        .msr_rd_en(msr_rd_en), .msr_rd_data(msr_rd_data),
        .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2),
        .modem_evt(modem_evt)
    );

    // Behavioural reference state
    int m_s1, m_s2, m_ctl, m_stat, m_flag;
    int src, ed, bitv;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_ctl = 0; m_stat = 0; m_flag = 0;
        end else begin
            if (m_ctl & 16)
                src = ((m_ctl >> 1) & 1) | ((m_ctl & 1) << 1) |
                      (((m_ctl >> 2) & 1) << 2) | (((m_ctl >> 3) & 1) << 3);
            else
                src = m_s2;
            ed = 0;
            for (int k = 0; k < 4; k++) begin
                bitv = 1 << k;
                if (k == 2) begin
                    if ((m_stat & bitv) != 0 && (src & bitv) == 0) ed |= bitv;
                end else if ((m_stat & bitv) != (src & bitv)) ed |= bitv;
            end
            m_flag = (msr_rd_en ? 0 : m_flag) | ed | (msr_wr_en ? (msr_wr_data & 15) : 0);
            m_stat = src;
            m_s2   = m_s1;
            m_s1   = line_cts | (line_dsr << 1) | (line_ri << 2) | (line_dcd << 3);
            if (mcr_wr_en) m_ctl = mcr_wr_data & 31;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int loop;
            loop = (m_ctl >> 4) & 1;
            chk(msr_rd_data[7:4], m_stat, loop ? "R6 status" : "R5 status");
            chk(msr_rd_data[3:0], m_flag, "R7 flags");
            chk(mcr_rd_data, m_ctl, "R2 ctl read");
            chk({pin_out2, pin_out1, pin_rts, pin_dtr},
                ((m_ctl & 12) | (loop ? 0 : (m_ctl & 3))), loop ? "R4 pins" : "R3 pins");
            chk(modem_evt, (m_flag != 0), "R12 event");
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        mcr_wr_en = 1; mcr_wr_data = v;
        @(negedge clk);
        mcr_wr_en = 0;
    endtask

    task automatic rd_stat(input int exp_before, input string tag);
        msr_rd_en = 1;
        chk(msr_rd_data, exp_before, tag);
        @(negedge clk);
        msr_rd_en = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        // R1 reset state
        chk(msr_rd_data, 0, "R1 msr");
        chk(mcr_rd_data, 0, "R1 mcr");
        chk({pin_out2, pin_out1, pin_rts, pin_dtr, modem_evt}, 0, "R1 pins");

        // R2 and R3: upper bits dropped, pins follow
        wr_ctl(8'hEF);
        chk(mcr_rd_data, 8'h0F, "R2 upper zero");
        chk({pin_out2, pin_out1, pin_rts, pin_dtr}, 4'hF, "R3 pins");

        // R5/R7/R12: clear-to-send rises
        line_cts = 1;
        wait_n(3);
        chk(msr_rd_data, 8'h11, "R7 cts flag");
        chk(modem_evt, 1, "R12 evt set");
        rd_stat(8'h11, "R10 read value");
        chk(msr_rd_data, 8'h10, "R10 cleared");
        chk(modem_evt, 0, "R12 evt clear");

        // R8: ring rise gives no flag, fall does
        line_ri = 1;
        wait_n(3);
        chk(msr_rd_data, 8'h50, "R8 ring rise quiet");
        line_ri = 0;
        wait_n(3);
        chk(msr_rd_data, 8'h14, "R8 ring fall");
        rd_stat(8'h14, "R10 read");

        // R9: flags accumulate
        line_dsr = 1;
        wait_n(3);
        line_dcd = 1;
        wait_n(3);
        chk(msr_rd_data, 8'hB0 | 8'h0A, "R9 sticky");
        rd_stat(8'hBA, "R10 read");
        chk(msr_rd_data, 8'hB0, "R10 status kept");

        // R11: host write sets flags only
        msr_wr_en = 1; msr_wr_data = 8'h05;
        @(negedge clk);
        msr_wr_en = 0;
        chk(msr_rd_data, 8'hB5, "R11 write flags");
        rd_stat(8'hB5, "R10 read");

        // R4/R6: loopback with terminal-ready and request-to-send
        wr_ctl(8'h13);
        chk({pin_rts, pin_dtr}, 0, "R4 pins held");
        @(negedge clk);
        chk(msr_rd_data, 8'h38, "R6 loop map");
        line_cts = 0; line_dsr = 0; line_dcd = 0;
        wait_n(4);
        chk(msr_rd_data[7:4], 4'h3, "R6 lines ignored");

        // R10: read coincides with new carrier flag
        mcr_wr_en = 1; mcr_wr_data = 8'h1B;
        @(negedge clk);
        mcr_wr_en = 0;
        rd_stat(8'h38, "R10 read");
        chk(msr_rd_data, 8'hB8, "R10 new flag survives");
        rd_stat(8'hB8, "R10 read");

        // leave loopback
        wr_ctl(8'h03);
        chk({pin_rts, pin_dtr}, 2'b11, "R3 pins restored");
        wait_n(6);
        finish_run();
    end
endmodule